// File: doc/BRIEF.md
# Time-Interval Result Combiner for a Counter-and-Interpolator TDC

This block turns the raw states captured at a START event and a STOP event into one signed time-interval word. Each event supplies three snapshots: the state of a free-running 8-bit reference-cycle counter, a 16-tap coarse delay-line snapshot that splits one reference period into 16 phases, and a 16-element fine snapshot that spans two coarse taps. Each snapshot is decoded independently. The three parts are then merged into a timestamp whose LSB is 1/128 of the reference period.

The fine snapshot has four guard elements at each end. These absorb path mismatch, so the nominal fine range sits in the middle eight elements and an offset of four is removed from the fine index. The START timestamp is held inside the block until a STOP arrives. One register stage after the STOP strobe, the block presents the STOP-minus-START difference together with a one-cycle valid pulse and an error flag. The analog delay lines, the loop locking and the capture latches are outside the block, and their snapshots arrive as plain vectors.

Top module: `tdc_result_combiner`

## Requirements
- R1: While reset is high, and in the first cycle after it, `result_valid`, `result_error` and `interval` are all 0.
- R2: A delay-line or fine snapshot is decoded as a thermometer code with bit 0 as the earliest tap. Its index k is the number of consecutive 1s starting at bit 0, which is the position of the first 1-to-0 transition. The snapshot `(1<<k)-1` decodes to k, for k from 0 to 15.
- R3: A snapshot with a 1 above a 0, or with all 16 bits at 1 (no transition), is a bad code. A bad code in any snapshot of either event sets `result_error` with the result of that pair.
- R4: The timestamp of an event is count*128 + coarse_index*8 + fine_index - 4. Fine indices 0 to 3 and 12 to 15 (the guard elements) are still accepted without error.
- R5: In the cycle after `stop_strobe` is sampled high, `interval` equals (stop timestamp - start timestamp) modulo 2^16, read as two's complement. This includes pairs where the counter has wrapped.
- R6: `result_valid` is high for exactly one cycle for each cycle in which `stop_strobe` is sampled high, and is low otherwise.
- R7: A STOP with no START captured since reset or since the previous STOP gives `result_error` = 1.
- R8: A `start_strobe` without `stop_strobe` produces no `result_valid`. It leaves `interval` and `result_error` unchanged.
- R9: When both strobes are high in the same cycle, the STOP is paired with the previously held START. The new START is held for the next STOP.
- R10: A pair in which all six snapshots are good codes and the START was armed reports `result_error` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| start_strobe | input | 1 | START snapshots are valid this cycle |
| start_count | input | 8 | Counter state captured at START |
| start_coarse | input | 16 | Coarse delay-line snapshot at START |
| start_fine | input | 16 | Fine interpolator snapshot at START |
| stop_strobe | input | 1 | STOP snapshots are valid this cycle |
| stop_count | input | 8 | Counter state captured at STOP |
| stop_coarse | input | 16 | Coarse delay-line snapshot at STOP |
| stop_fine | input | 16 | Fine interpolator snapshot at STOP |
| result_valid | output | 1 | One-cycle pulse: a new result is on the outputs |
| interval | output | 16 | STOP minus START, in 1/128 reference-period units |
| result_error | output | 1 | Bad snapshot code or unarmed STOP in this result |

## Verification
The assertions assume that the snapshot vectors are stable and meaningful only in a cycle where their strobe is high, and that strobes are single-cycle events. The checker therefore inspects code validity only when a strobe is present. The stimulus drives the strobes for one cycle at a time and changes the vectors only on the falling clock edge. Random pairs use well-formed thermometer codes with any counter value, so that the interval arithmetic is compared exactly. Directed cases then inject broken codes, all-ones codes, guard-element indices, STOPs with no START, coincident strobes and counter wrap.

// File: rtl/tdc_cmb_pkg.sv
package tdc_cmb_pkg;

    // Capture geometry
    localparam int COUNT_W      = 8;
    localparam int COARSE_TAPS  = 16;
    localparam int FINE_ELEMS   = 16;
    localparam int FINE_GUARD   = 4;

    // Derived scaling
    localparam int COARSE_IDX_W = $clog2(COARSE_TAPS);
    localparam int FINE_IDX_W   = $clog2(FINE_ELEMS);
    localparam int FINE_PER_TAP = FINE_ELEMS / 2;               // fine span covers two taps
    localparam int LSB_PER_REF  = COARSE_TAPS * FINE_PER_TAP;   // 128
    localparam int TAP_SHIFT    = $clog2(FINE_PER_TAP);
    localparam int CYCLE_SHIFT  = $clog2(LSB_PER_REF);
    localparam int STAMP_W      = COUNT_W + CYCLE_SHIFT + 2;    // headroom plus sign
    localparam int OUT_W        = 16;

    typedef logic signed [STAMP_W-1:0] stamp_t;

    typedef struct packed {
        stamp_t stamp;
        logic   bad;
    } event_stamp_t;

    // Merge the three decoded parts into one timestamp
    function automatic stamp_t merge_parts(
        input logic [COUNT_W-1:0]      cnt,
        input logic [COARSE_IDX_W-1:0] cidx,
        input logic [FINE_IDX_W-1:0]   fidx
    );
        stamp_t c_part;
        stamp_t t_part;
        stamp_t f_part;
        c_part = stamp_t'(cnt)  <<< CYCLE_SHIFT;
        t_part = stamp_t'(cidx) <<< TAP_SHIFT;
        f_part = stamp_t'(fidx) - stamp_t'(FINE_GUARD);
        return c_part + t_part + f_part;
    endfunction

endpackage

// File: rtl/therm_decode.sv
module therm_decode #(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] snap,
    output logic [IDX_W-1:0] idx,
    output logic             bad
);
    logic [IDX_W:0] ones_run;
    logic           in_run;

    always_comb begin
        in_run   = 1'b1;
        ones_run = '0;
        bad      = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (snap[i]) begin
                if (in_run) ones_run = ones_run + (IDX_W+1)'(1);
                else        bad      = 1'b1;   // bubble above a zero
            end else begin
                in_run = 1'b0;
            end
        end
        if (in_run) bad = 1'b1;                // no transition in the window
        idx = ones_run[IDX_W-1:0];
    end
endmodule

// File: rtl/event_stamper.sv
module event_stamper
    import tdc_cmb_pkg::*;
(
    input  logic [COUNT_W-1:0]     cnt,
    input  logic [COARSE_TAPS-1:0] coarse_snap,
    input  logic [FINE_ELEMS-1:0]  fine_snap,
    output event_stamp_t           ev
);
    logic [COARSE_IDX_W-1:0] c_idx;
    logic [FINE_IDX_W-1:0]   f_idx;
    logic                    c_bad;
    logic                    f_bad;

    therm_decode #(.WIDTH(COARSE_TAPS)) u_coarse_dec (
        .snap (coarse_snap),
        .idx  (c_idx),
        .bad  (c_bad)
    );

    therm_decode #(.WIDTH(FINE_ELEMS)) u_fine_dec (
        .snap (fine_snap),
        .idx  (f_idx),
        .bad  (f_bad)
    );

    always_comb begin
        ev.stamp = merge_parts(cnt, c_idx, f_idx);
        ev.bad   = c_bad | f_bad;
    end
endmodule

// File: rtl/tdc_result_combiner.sv
module tdc_result_combiner
    import tdc_cmb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_strobe,
    input  logic [COUNT_W-1:0]     start_count,
    input  logic [COARSE_TAPS-1:0] start_coarse,
    input  logic [FINE_ELEMS-1:0]  start_fine,
    input  logic                   stop_strobe,
    input  logic [COUNT_W-1:0]     stop_count,
    input  logic [COARSE_TAPS-1:0] stop_coarse,
    input  logic [FINE_ELEMS-1:0]  stop_fine,
    output logic                   result_valid,
    output logic [OUT_W-1:0]       interval,
    output logic                   result_error
);
    event_stamp_t start_ev;
    event_stamp_t stop_ev;
    stamp_t       held_stamp;
    logic         held_bad;
    logic         armed;
    stamp_t       diff;

    event_stamper u_start_stamp (
        .cnt         (start_count),
        .coarse_snap (start_coarse),
        .fine_snap   (start_fine),
        .ev          (start_ev)
    );

    event_stamper u_stop_stamp (
        .cnt         (stop_count),
        .coarse_snap (stop_coarse),
        .fine_snap   (stop_fine),
        .ev          (stop_ev)
    );

    assign diff = stop_ev.stamp - held_stamp;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_stamp   <= '0;
            held_bad     <= 1'b0;
            armed        <= 1'b0;
            result_valid <= 1'b0;
            interval     <= '0;
            result_error <= 1'b0;
        end else begin
            result_valid <= stop_strobe;
            if (stop_strobe) begin
                interval     <= diff[OUT_W-1:0];
                result_error <= stop_ev.bad | held_bad | ~armed;
            end
            if (start_strobe) begin
                held_stamp <= start_ev.stamp;
                held_bad   <= start_ev.bad;
                armed      <= 1'b1;
            end else if (stop_strobe) begin
                armed      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdc_result_combiner_chk.sv
module tdc_result_combiner_chk
    import tdc_cmb_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   start_strobe,
    input logic [COUNT_W-1:0]     start_count,
    input logic [COARSE_TAPS-1:0] start_coarse,
    input logic [FINE_ELEMS-1:0]  start_fine,
    input logic                   stop_strobe,
    input logic [COUNT_W-1:0]     stop_count,
    input logic [COARSE_TAPS-1:0] stop_coarse,
    input logic [FINE_ELEMS-1:0]  stop_fine,
    input logic                   result_valid,
    input logic [OUT_W-1:0]       interval,
    input logic                   result_error
);
    // Contiguous ones from bit 0 make snap+1 a power of two; all ones is rejected.
    function automatic logic good_code(input logic [15:0] s);
        return ((s & (s + 16'd1)) == 16'd0) && (s != 16'hFFFF);
    endfunction

    logic stop_codes_ok;
    assign stop_codes_ok = good_code(stop_coarse) && good_code(stop_fine);

    logic mon_armed;
    always_ff @(posedge clk) begin
        if (rst)               mon_armed <= 1'b0;
        else if (start_strobe) mon_armed <= 1'b1;
        else if (stop_strobe)  mon_armed <= 1'b0;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!result_valid && !result_error && interval == '0));

    p_bad_stop_code_r3: assert property (@(posedge clk) disable iff (rst)
        (stop_strobe && !stop_codes_ok) |=> result_error);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        stop_strobe |=> result_valid);

    p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !stop_strobe |=> !result_valid);

    p_unarmed_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (stop_strobe && !mon_armed) |=> result_error);

    p_start_only_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !stop_strobe |=> ($stable(interval) && $stable(result_error)));
endmodule

bind tdc_result_combiner tdc_result_combiner_chk u_chk (.*);

// File: tb/tdc_result_combiner_bench.sv
`timescale 1ns/1ps
module tdc_result_combiner_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_strobe, stop_strobe;
    logic [7:0]  start_count, stop_count;
    logic [15:0] start_coarse, start_fine, stop_coarse, stop_fine;
    logic        result_valid;
    logic [15:0] interval;
    logic        result_error;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    tdc_result_combiner u_tdc_result_combiner (
        .clk(clk), .rst(rst),
        .start_strobe(start_strobe), .start_count(start_count),
        .start_coarse(start_coarse), .start_fine(start_fine),
        .stop_strobe(stop_strobe), .stop_count(stop_count),
        .stop_coarse(stop_coarse), .stop_fine(stop_fine),
        .result_valid(result_valid), .interval(interval),
        .result_error(result_error)
    );

    function automatic logic [15:0] therm(input int k);
        return (k >= 16) ? 16'hFFFF : 16'((32'd1 << k) - 1);
    endfunction

    function automatic int stamp(input int cnt, input int c, input int f);
        return cnt * 128 + c * 8 + f - 4;
    endfunction

    function automatic logic [15:0] diff16(input int a_stop, input int b_start);
        return 16'(a_stop - b_start);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle of strobes; returns at the falling edge after the capturing edge.
    task automatic pulse(input logic st, input logic [7:0] sc, input logic [15:0] scs, input logic [15:0] sfs,
                         input logic sp, input logic [7:0] pc, input logic [15:0] pcs, input logic [15:0] pfs);
        @(negedge clk);
        start_strobe = st; start_count = sc; start_coarse = scs; start_fine = sfs;
        stop_strobe  = sp; stop_count  = pc; stop_coarse  = pcs; stop_fine  = pfs;
        @(negedge clk);
        start_strobe = 1'b0;
        stop_strobe  = 1'b0;
    endtask

    task automatic do_start(input int cnt, input logic [15:0] c, input logic [15:0] f);
        pulse(1'b1, 8'(cnt), c, f, 1'b0, 8'd0, 16'd1, 16'd1);
    endtask

    task automatic do_stop(input int cnt, input logic [15:0] c, input logic [15:0] f);
        pulse(1'b0, 8'd0, 16'd1, 16'd1, 1'b1, 8'(cnt), c, f);
    endtask

    initial begin
        #(200000.0 * 5.0);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int sa, sb, st_a;
        logic [15:0] hold_iv;
        logic        hold_err;
        void'($urandom(32'h5eed_7dc1));
        rst = 1'b1;
        start_strobe = 0; stop_strobe = 0;
        start_count = 0; stop_count = 0;
        start_coarse = 16'd1; start_fine = 16'd1; stop_coarse = 16'd1; stop_fine = 16'd1;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", result_valid, 0);
        chk("R1 interval in reset", interval, 0);
        chk("R1 error in reset", result_error, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", result_valid, 0);

        // R2/R4: directed decode of every coarse and fine index
        for (int k = 0; k < 16; k++) begin
            do_start(10, therm(0), therm(4));
            do_stop(10, therm(k), therm(15 - k));
            chk("R2 decode interval", interval, diff16(stamp(10, k, 15 - k), stamp(10, 0, 4)));
            chk("R10 good pair no error", result_error, 0);
        end

        // R4: guard indices accepted; start at fine 0 (stamp below zero)
        do_start(0, therm(0), therm(0));
        do_stop(0, therm(0), therm(15));
        chk("R4 guard span interval", interval, 15);
        chk("R4 guard not error", result_error, 0);

        // R5: random pairs, including counter wrap and negative differences
        for (int n = 0; n < 60; n++) begin
            int c0, c1, t0, t1, f0, f1;
            c0 = int'($urandom_range(255)); c1 = int'($urandom_range(255));
            t0 = int'($urandom_range(15));  t1 = int'($urandom_range(15));
            f0 = int'($urandom_range(15));  f1 = int'($urandom_range(15));
            do_start(c0, therm(t0), therm(f0));
            do_stop(c1, therm(t1), therm(f1));
            chk("R5 random interval", interval, diff16(stamp(c1, t1, f1), stamp(c0, t0, f0)));
            chk("R10 random no error", result_error, 0);
        end

        // R5: explicit wrap, stop counter below start counter
        do_start(250, therm(3), therm(8));
        do_stop(5, therm(1), therm(6));
        chk("R5 wrap interval", interval, diff16(stamp(5, 1, 6), stamp(250, 3, 8)));

        // R6: pulse width
        do_start(1, therm(2), therm(5));
        pulse(1'b0, 8'd0, 16'd1, 16'd1, 1'b1, 8'd3, therm(2), therm(5));
        chk("R6 valid high after stop", result_valid, 1);
        @(negedge clk);
        chk("R6 valid back low", result_valid, 0);

        // R8: start alone keeps outputs
        hold_iv = interval; hold_err = result_error;
        do_start(77, therm(9), therm(9));
        chk("R8 no valid on start", result_valid, 0);
        chk("R8 interval held", interval, hold_iv);
        chk("R8 error held", result_error, hold_err);
        do_stop(78, therm(9), therm(9));
        chk("R8 follow-up interval", interval, 128);

        // R3: bubble in stop coarse, all ones in stop fine, bad start fine
        do_start(4, therm(2), therm(6));
        do_stop(6, 16'h0005, therm(6));
        chk("R3 bubble coarse", result_error, 1);
        do_start(4, therm(2), therm(6));
        do_stop(6, therm(2), 16'hFFFF);
        chk("R3 all-ones fine", result_error, 1);
        do_start(4, therm(2), 16'h0F0F);
        do_stop(6, therm(2), therm(6));
        chk("R3 bad start code reported", result_error, 1);
        do_start(4, therm(2), therm(6));
        do_stop(6, therm(2), therm(6));
        chk("R10 error clears on good pair", result_error, 0);

        // R7: stop right after a stop, with no start between
        do_stop(9, therm(1), therm(5));
        chk("R7 unarmed stop error", result_error, 1);
        chk("R7 unarmed stop valid", result_valid, 1);

        // R9: coincident strobes
        sa = stamp(20, 5, 7);
        do_start(20, therm(5), therm(7));
        st_a = stamp(30, 1, 3);
        sb = stamp(22, 8, 10);
        pulse(1'b1, 8'd30, therm(1), therm(3), 1'b1, 8'd22, therm(8), therm(10));
        chk("R9 stop pairs with older start", interval, diff16(sb, sa));
        chk("R9 coincident no error", result_error, 0);
        do_stop(31, therm(0), therm(4));
        chk("R9 new start kept", interval, diff16(stamp(31, 0, 4), st_a));
        chk("R9 rearmed no error", result_error, 0);

        // R1: reset mid-stream clears outputs
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 interval after re-reset", interval, 0);
        do_stop(3, therm(1), therm(4));
        chk("R7 stop after reset unarmed", result_error, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule